// File: doc/BRIEF.md
# Multidrop Receive Address Filter

This block sits between a UART receiver and the host side of a node on a shared multidrop line. Each byte coming out of the receiver carries a flag saying whether it is a node address or payload. The filter holds a programmable node address and a compare-mode switch. When compare mode is off, every byte goes through to the host. When it is on, address bytes are compared with the node address. Payload bytes reach the host only while the most recent address byte matched.

A byte that passes is latched into a holding register. It raises a data-available flag and a level receive interrupt, and both stay up until the host acknowledges the read. A byte that is filtered out leaves the holding register, the flag and the interrupt untouched. The two configuration registers are written and read through a small select-based port.

Top module: `mdrx_addr_filter`

## Requirements
- R1: The node address register is DATA_W bits wide and resets to zero. A write with `cfg_we`=1 and `cfg_sel`=0 loads `cfg_wdata`, and `cfg_rdata` returns it while `cfg_sel`=0.
- R2: With compare mode off, every strobed byte, address or payload, appears on `rx_data` one cycle after `rx_stb`, with `data_avail` and `rx_irq` set.
- R3: With compare mode on, an address byte equal to the node address selects the node and is delivered like any passed byte (DELIVER_ADDR=1).
- R4: With compare mode on, an address byte that differs from the node address is not delivered and deselects the node.
- R5: With compare mode on, a payload byte is delivered only while the node is selected. Otherwise it is dropped, and `rx_data`, `data_avail` and `rx_irq` keep their values.
- R6: `rd_ack` clears `data_avail` and `rx_irq` on the next cycle. If a passed byte arrives in the same cycle, the new byte wins and both stay set.
- R7: The selected state resets to cleared, so payload that arrives after reset in compare mode is dropped until an address matches.
- R8: While compare mode is off, the selected state is cleared. After compare mode is turned off and back on, payload is dropped until a new match.
- R9: The control register is written with `cfg_sel`=1, and compare mode is bit 0 of `cfg_wdata`. Reading with `cfg_sel`=1 returns the mode in bit 0 and zeros above it. Compare mode resets to off.
- R10: After reset, `data_avail`, `rx_irq` and `rx_data` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_stb | input | 1 | One-cycle strobe for a received byte |
| rx_byte | input | DATA_W | Received byte value |
| rx_is_addr | input | 1 | 1 = byte is a node address, 0 = payload |
| cfg_we | input | 1 | Configuration write enable |
| cfg_sel | input | 1 | 0 = node address register, 1 = control register |
| cfg_wdata | input | DATA_W | Configuration write data |
| cfg_rdata | output | DATA_W | Read data of the selected configuration register |
| rd_ack | input | 1 | Host has read `rx_data` |
| data_avail | output | 1 | A delivered byte is waiting |
| rx_irq | output | 1 | Receive interrupt request (level) |
| rx_data | output | DATA_W | Last delivered byte |

## Verification
The bench builds the block with its defaults, DATA_W=8 and DELIVER_ADDR=1, so a matching address byte is itself delivered. That gives the scoreboard an entry for every match and lets one queue track both address and payload delivery. The byte width covers the full 0x00 to 0xFF range of node addresses, so the extreme values 0x00 (the reset address) and 0xFF are both reachable as matches and mismatches. The bench also toggles compare mode while the node is selected and overlaps an acknowledge with a new byte, to reach the deselect and priority corners.

// File: rtl/mdf_pkg.sv
package mdf_pkg;
   // Configuration register select codes
   typedef enum logic [0:0] {
      CFG_NODE = 1'b0,
      CFG_CTRL = 1'b1
   } cfg_sel_e;

   // Bit position of compare mode inside the control register
   localparam int unsigned CTRL_MODE_BIT = 0;
endpackage

// File: rtl/mdf_cfg_regs.sv
module mdf_cfg_regs
   import mdf_pkg::*;
#(
   parameter int unsigned DATA_W     = 8,
   parameter logic [DATA_W-1:0] NODE_RESET = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic              cfg_sel,
   input  logic [DATA_W-1:0] cfg_wdata,
   output logic [DATA_W-1:0] cfg_rdata,
   output logic [DATA_W-1:0] node_addr,
   output logic              cmp_mode
);
   localparam int unsigned PAD_W = DATA_W - 1;

   cfg_sel_e              sel_e;
   logic [DATA_W-1:0]     node_q;
   logic                  mode_q;

   assign sel_e = cfg_sel_e'(cfg_sel);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         node_q <= NODE_RESET;
         mode_q <= 1'b0;
      end else if (cfg_we) begin
         if (sel_e == CFG_NODE) node_q <= cfg_wdata;
         else                   mode_q <= cfg_wdata[CTRL_MODE_BIT];
      end
   end

   always_comb begin
      if (sel_e == CFG_NODE) cfg_rdata = node_q;
      else                   cfg_rdata = {{PAD_W{1'b0}}, mode_q};
   end

   assign node_addr = node_q;
   assign cmp_mode  = mode_q;
endmodule

// File: rtl/mdf_addr_match.sv
module mdf_addr_match #(
   parameter int unsigned DATA_W       = 8,
   parameter bit          DELIVER_ADDR = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_stb,
   input  logic [DATA_W-1:0] rx_byte,
   input  logic              rx_is_addr,
   input  logic              cmp_mode,
   input  logic [DATA_W-1:0] node_addr,
   output logic              accept,
   output logic              selected
);
   logic hit;
   logic sel_q;
   logic addr_pass;

   assign hit = (rx_byte == node_addr);

   // Selection state: updated by address bytes in compare mode,
   // held cleared while compare mode is off.
   always_ff @(posedge clk) begin
      if (!rst_n)                          sel_q <= 1'b0;
      else if (!cmp_mode)                  sel_q <= 1'b0;
      else if (rx_stb && rx_is_addr)       sel_q <= hit;
   end

   generate
      if (DELIVER_ADDR) begin : g_addr_fwd
         assign addr_pass = hit;
      end else begin : g_addr_drop
         assign addr_pass = 1'b0;
      end
   endgenerate

   always_comb begin
      if (!rx_stb)         accept = 1'b0;
      else if (!cmp_mode)  accept = 1'b1;
      else if (rx_is_addr) accept = addr_pass;
      else                 accept = sel_q;
   end

   assign selected = sel_q;
endmodule

// File: rtl/mdf_rx_hold.sv
module mdf_rx_hold #(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  logic [DATA_W-1:0] rx_byte,
   input  logic              rd_ack,
   output logic [DATA_W-1:0] rx_data,
   output logic              data_avail,
   output logic              rx_irq
);
   logic [DATA_W-1:0] data_q;
   logic              avail_q;
   logic              irq_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         data_q <= '0;
      end else if (accept) begin
         data_q <= rx_byte;
      end
   end

   // A new byte outranks an acknowledge in the same cycle.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         avail_q <= 1'b0;
         irq_q   <= 1'b0;
      end else if (accept) begin
         avail_q <= 1'b1;
         irq_q   <= 1'b1;
      end else if (rd_ack) begin
         avail_q <= 1'b0;
         irq_q   <= 1'b0;
      end
   end

   assign rx_data    = data_q;
   assign data_avail = avail_q;
   assign rx_irq     = irq_q;
endmodule

// File: rtl/mdrx_addr_filter.sv
module mdrx_addr_filter #(
   parameter int unsigned DATA_W       = 8,
   parameter bit          DELIVER_ADDR = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_stb,
   input  logic [DATA_W-1:0] rx_byte,
   input  logic              rx_is_addr,
   input  logic              cfg_we,
   input  logic              cfg_sel,
   input  logic [DATA_W-1:0] cfg_wdata,
   output logic [DATA_W-1:0] cfg_rdata,
   input  logic              rd_ack,
   output logic              data_avail,
   output logic              rx_irq,
   output logic [DATA_W-1:0] rx_data
);
   localparam logic [DATA_W-1:0] NODE_RESET = '0;

   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("mdrx_addr_filter: DATA_W must be at least 2");
      end
   endgenerate

   logic [DATA_W-1:0] node_q;
   logic              mode_q;
   logic              sel_q;
   logic              accept;

   mdf_cfg_regs #(
      .DATA_W     (DATA_W),
      .NODE_RESET (NODE_RESET)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_we    (cfg_we),
      .cfg_sel   (cfg_sel),
      .cfg_wdata (cfg_wdata),
      .cfg_rdata (cfg_rdata),
      .node_addr (node_q),
      .cmp_mode  (mode_q)
   );

   mdf_addr_match #(
      .DATA_W       (DATA_W),
      .DELIVER_ADDR (DELIVER_ADDR)
   ) u_match (
      .clk        (clk),
      .rst_n      (rst_n),
      .rx_stb     (rx_stb),
      .rx_byte    (rx_byte),
      .rx_is_addr (rx_is_addr),
      .cmp_mode   (mode_q),
      .node_addr  (node_q),
      .accept     (accept),
      .selected   (sel_q)
   );

   mdf_rx_hold #(
      .DATA_W (DATA_W)
   ) u_hold (
      .clk        (clk),
      .rst_n      (rst_n),
      .accept     (accept),
      .rx_byte    (rx_byte),
      .rd_ack     (rd_ack),
      .rx_data    (rx_data),
      .data_avail (data_avail),
      .rx_irq     (rx_irq)
   );
endmodule

// File: rtl/mdrx_addr_filter_chk.sv
module mdrx_addr_filter_chk #(
   parameter int unsigned DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rx_stb,
   input logic [DATA_W-1:0] rx_byte,
   input logic              rx_is_addr,
   input logic              rd_ack,
   input logic              data_avail,
   input logic              rx_irq,
   input logic [DATA_W-1:0] rx_data,
   input logic              mode,
   input logic              sel,
   input logic [DATA_W-1:0] node
);
   // R2: open mode passes every byte
   a_r2_open_pass: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_stb && !mode) |=> (data_avail && rx_irq && rx_data == $past(rx_byte)));

   // R3: matching address selects the node
   a_r3_match_selects: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_stb && mode && rx_is_addr && rx_byte == node) |=> sel);

   // R4: mismatching address deselects
   a_r4_miss_deselects: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_stb && mode && rx_is_addr && rx_byte != node) |=> !sel);

   // R5: payload while deselected leaves the held byte alone
   a_r5_drop_keeps_data: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_stb && mode && !rx_is_addr && !sel) |=> $stable(rx_data));

   // R5: dropped payload never raises the flag on its own
   a_r5_drop_no_raise: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_stb && mode && !rx_is_addr && !sel && !data_avail) |=> !data_avail);

   // R6: acknowledge without a new byte clears the flag and interrupt
   a_r6_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_ack && !rx_stb) |=> (!data_avail && !rx_irq));

   // R8: selection is cleared while compare mode is off
   a_r8_off_deselects: assert property (@(posedge clk) disable iff (!rst_n)
      !mode |=> !sel);

   // R6: the interrupt never stands without a waiting byte
   always @(negedge clk) begin
      if (rst_n) begin
         a_r6_irq_with_avail: assert (!rx_irq || data_avail);
      end
   end
endmodule

bind mdrx_addr_filter mdrx_addr_filter_chk #(.DATA_W(DATA_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .rx_stb     (rx_stb),
   .rx_byte    (rx_byte),
   .rx_is_addr (rx_is_addr),
   .rd_ack     (rd_ack),
   .data_avail (data_avail),
   .rx_irq     (rx_irq),
   .rx_data    (rx_data),
   .mode       (mode_q),
   .sel        (sel_q),
   .node       (node_q)
);

// File: tb/mdrx_addr_filter_tb_top.sv
module mdrx_addr_filter_tb_top;
   localparam int unsigned DW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          rx_stb = 1'b0;
   logic [DW-1:0] rx_byte = '0;
   logic          rx_is_addr = 1'b0;
   logic          cfg_we = 1'b0;
   logic          cfg_sel = 1'b0;
   logic [DW-1:0] cfg_wdata = '0;
   logic [DW-1:0] cfg_rdata;
   logic          rd_ack = 1'b0;
   logic          data_avail;
   logic          rx_irq;
   logic [DW-1:0] rx_data;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   bit mon_en = 1'b0;
   bit done   = 1'b0;

   // reference model state
   logic [DW-1:0] m_node = '0;
   bit            m_mode = 1'b0;
   bit            m_sel  = 1'b0;
   logic [DW-1:0] m_last = '0;
   logic [DW-1:0] exp_q[$];

   always #10 clk = ~clk;   // 50 MHz

   mdrx_addr_filter dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .rx_stb     (rx_stb),
      .rx_byte    (rx_byte),
      .rx_is_addr (rx_is_addr),
      .cfg_we     (cfg_we),
      .cfg_sel    (cfg_sel),
      .cfg_wdata  (cfg_wdata),
      .cfg_rdata  (cfg_rdata),
      .rd_ack     (rd_ack),
      .data_avail (data_avail),
      .rx_irq     (rx_irq),
      .rx_data    (rx_data)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic cfg_write(input bit sel, input logic [DW-1:0] val);
      @(negedge clk);
      cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = val;
      @(negedge clk);
      cfg_we = 1'b0;
      if (!sel) m_node = val;
      else begin
         m_mode = val[0];
         if (!m_mode) m_sel = 1'b0;
      end
   endtask

   // driver: pushes expected deliveries into the scoreboard
   task automatic send(input string req, input logic [DW-1:0] b, input bit is_addr);
      bit acc;
      acc = !m_mode || (is_addr ? (b == m_node) : m_sel);
      if (m_mode && is_addr) m_sel = (b == m_node);
      @(negedge clk);
      rx_stb = 1'b1; rx_byte = b; rx_is_addr = is_addr;
      if (acc) begin
         exp_q.push_back(b);
         m_last = b;
      end
      @(negedge clk);
      rx_stb = 1'b0;
      if (!acc) begin
         chk({req, " dropped byte leaves rx_data"}, rx_data, m_last);
         chk({req, " dropped byte no data_avail"}, data_avail, 1'b0);
      end
      repeat (3) @(negedge clk);
   endtask

   // monitor: pops expectations as the design delivers
   always @(negedge clk) begin
      if (mon_en) begin
         if (rd_ack) rd_ack = 1'b0;
         else if (data_avail) begin
            if (exp_q.size() == 0) begin
               checks++; errors++;
               $display("FAIL R5 unexpected delivery actual=0x%0h expected=none", rx_data);
            end else begin
               logic [DW-1:0] e;
               e = exp_q.pop_front();
               chk("R2/R3/R5 delivered byte", rx_data, e);
               chk("R2/R3/R5 irq with delivery", rx_irq, 1'b1);
            end
            rd_ack = 1'b1;
         end
      end
   end

   // watchdog
   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000 && !done) begin
         done = 1'b1;
         checks++; errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R10 / R1 / R9 reset state
      chk("R10 data_avail reset", data_avail, 1'b0);
      chk("R10 rx_irq reset", rx_irq, 1'b0);
      chk("R10 rx_data reset", rx_data, 8'h00);
      cfg_sel = 1'b0; #1;
      chk("R1 node reset", cfg_rdata, 8'h00);
      cfg_sel = 1'b1; #1;
      chk("R9 mode reset off", cfg_rdata, 8'h00);

      mon_en = 1'b1;
      // R2 open mode
      send("R2", 8'h12, 1'b0);
      send("R2", 8'h55, 1'b1);
      send("R2", 8'hA0, 1'b0);

      // R1 / R9 configuration
      cfg_write(1'b0, 8'h5A);
      cfg_sel = 1'b0; #1;
      chk("R1 node readback", cfg_rdata, 8'h5A);
      cfg_write(1'b1, 8'hFF);
      cfg_sel = 1'b1; #1;
      chk("R9 ctrl readback bit0 only", cfg_rdata, 8'h01);

      // R7 payload before any match
      send("R7", 8'h33, 1'b0);
      // R4 mismatch, then payload dropped
      send("R4", 8'h11, 1'b1);
      send("R5", 8'h44, 1'b0);
      // R3 match, R5 payload passes
      send("R3", 8'h5A, 1'b1);
      send("R5", 8'h01, 1'b0);
      send("R5", 8'h02, 1'b0);
      // R4 deselect by other address
      send("R4", 8'h77, 1'b1);
      send("R5", 8'h03, 1'b0);
      // R8 mode off clears selection
      send("R3", 8'h5A, 1'b1);
      send("R5", 8'h09, 1'b0);
      cfg_write(1'b1, 8'h00);
      cfg_write(1'b1, 8'h01);
      send("R8", 8'h0A, 1'b0);
      // extreme node values
      cfg_write(1'b0, 8'hFF);
      send("R4", 8'h00, 1'b1);
      send("R3", 8'hFF, 1'b1);
      send("R5", 8'h00, 1'b0);
      repeat (4) @(negedge clk);
      chk("R5 scoreboard drained", exp_q.size(), 0);

      // R6 directed: ack coinciding with a new byte
      mon_en = 1'b0;
      @(negedge clk);
      rd_ack = 1'b0;
      rx_stb = 1'b1; rx_byte = 8'hC3; rx_is_addr = 1'b0;
      @(negedge clk);
      rx_stb = 1'b0;
      chk("R6 avail set", data_avail, 1'b1);
      rx_stb = 1'b1; rx_byte = 8'h3C; rd_ack = 1'b1;
      @(negedge clk);
      rx_stb = 1'b0; rd_ack = 1'b0;
      chk("R6 new byte wins over ack avail", data_avail, 1'b1);
      chk("R6 new byte wins over ack irq", rx_irq, 1'b1);
      chk("R6 new byte data", rx_data, 8'h3C);
      rd_ack = 1'b1;
      @(negedge clk);
      rd_ack = 1'b0;
      chk("R6 ack clears avail", data_avail, 1'b0);
      chk("R6 ack clears irq", rx_irq, 1'b0);
      chk("R6 data kept after ack", rx_data, 8'h3C);

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule